// File: doc/BRIEF.md
# False Sharing Detection Probe

The probe sits next to a private L1 data cache. It keeps a word-level usage vector for every line: each bit stands for one word of the line and is set when the local core reads or writes that word. When a coherence invalidation arrives, it brings a remote word mask naming the words the remote requester touched. The probe compares that mask with the line's local vector and reports the invalidation as true, grey or false sharing.

Invalidations that show any false sharing (grey or false) are remembered in a small fully associative table. Each entry holds the full line address and the remote mask that caused the invalidation. When the local core later misses on a remembered address, the probe compares the stored remote mask with the words now requested. It reports the miss as true, grey or strict (avoidable), then drops the entry. Six saturating counters, one for each event kind, can be read through a select input. The cache arrays, the coherence protocol and the bus belong to the surrounding design.

Top module: `fs_probe`

## Requirements
- R1: A local access sets the bits of `acc_mask` in the usage vector of line `acc_line`. A fill clears the vector of `fill_line`; when a fill and an access name the same line in one cycle, the vector becomes exactly `acc_mask`.
- R2: An invalidation compares the usage vector of line `inv_addr[IDX_W-1:0]` with `inv_mask`. Kind 1 (true) means the two are equal and overlap. Kind 3 (false) means they share no bit. Kind 2 (grey) covers every other case.
- R3: A grey or false invalidation stores `inv_addr` and `inv_mask` in the map. A true invalidation stores nothing.
- R4: An invalidation clears the usage vector of its line after the vector has been classified.
- R5: A miss whose `miss_addr` matches a valid map entry is classified from the stored mask and `miss_mask`. Kind 1 (true) means they are equal and overlap, kind 3 (strict) means they are disjoint, and kind 2 (grey) covers every other case. A miss with no matching entry produces no event.
- R6: A map entry that a miss has matched is removed, so the next miss to the same address produces no event.
- R7: The map holds MAP_DEPTH entries (default 8), with at most one entry per address. Storing an address that is already present overwrites its mask. Otherwise the lowest free slot is used; when no slot is free, a round-robin pointer picks the victim, starting at slot 0.
- R8: Every event is a registered pulse of one cycle that appears in the cycle after the input that caused it.
- R9: `stat_sel` selects a counter: 0, 1 and 2 count true, grey and false invalidations; 3, 4 and 5 count true, grey and strict misses. Each counter stops at its maximum value.
- R10: After reset every counter reads 0, no event is raised, the map is empty and every usage vector is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Local access strobe |
| acc_line | input | IDX_W | Line index of the access |
| acc_mask | input | WORDS | Words read or written |
| fill_valid | input | 1 | Line fill strobe |
| fill_line | input | IDX_W | Line index being filled |
| inv_valid | input | 1 | Incoming invalidation strobe |
| inv_addr | input | ADDR_W | Line address being invalidated |
| inv_mask | input | WORDS | Words touched by the remote requester |
| miss_valid | input | 1 | Local miss strobe |
| miss_addr | input | ADDR_W | Line address of the miss |
| miss_mask | input | WORDS | Words requested by the miss |
| stat_sel | input | 3 | Counter select |
| inv_evt_valid | output | 1 | Invalidation event pulse |
| inv_evt_kind | output | 2 | 1 true, 2 grey, 3 false |
| miss_evt_valid | output | 1 | Classified miss pulse |
| miss_evt_kind | output | 2 | 1 true, 2 grey, 3 strict |
| stat_count | output | CNT_W | Selected counter value |

## Verification
The hardest state to reach is a full map in which one more false invalidation has to evict the oldest entry. From the ports, only a run of distinct addresses can produce it, each of them invalidated with no local words in use and none of them missed in between. The stimulus sends nine false invalidations to addresses that share one line index but differ in their upper bits. It then shows that the first address no longer classifies a miss, while the second and the last still do. That same run drives the false-invalidation counter past the reduced counter width that the bench uses, which exercises saturation.

// File: rtl/fs_probe.sv
module fs_probe #(
  parameter int WORDS     = 16,
  parameter int LINES     = 64,
  parameter int ADDR_W    = 32,
  parameter int MAP_DEPTH = 8,
  parameter int CNT_W     = 16,
  localparam int IDX_W    = $clog2(LINES),
  localparam int PTR_W    = $clog2(MAP_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [IDX_W-1:0]  acc_line,
  input  logic [WORDS-1:0]  acc_mask,
  input  logic              fill_valid,
  input  logic [IDX_W-1:0]  fill_line,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr,
  input  logic [WORDS-1:0]  inv_mask,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic [WORDS-1:0]  miss_mask,
  input  logic [2:0]        stat_sel,
  output logic              inv_evt_valid,
  output logic [1:0]        inv_evt_kind,
  output logic              miss_evt_valid,
  output logic [1:0]        miss_evt_kind,
  output logic [CNT_W-1:0]  stat_count
);
  localparam int NCNT = 6;

  logic [WORDS-1:0]  lvec     [LINES];
  logic [ADDR_W-1:0] map_addr [MAP_DEPTH];
  logic [WORDS-1:0]  map_vec  [MAP_DEPTH];
  logic [MAP_DEPTH-1:0] map_vld;
  logic [PTR_W-1:0]  rr;
  logic [CNT_W-1:0]  cnt [NCNT];

  function automatic logic [1:0] overlap_kind(input logic [WORDS-1:0] a, input logic [WORDS-1:0] b);
    if ((a & b) == '0) return 2'd3;
    else if (a == b)   return 2'd1;
    else               return 2'd2;
  endfunction

  logic [IDX_W-1:0] inv_line;
  logic [1:0]       inv_kind, miss_kind;
  logic             ins;
  logic             hit_any, match_any, free_any;
  logic [PTR_W-1:0] hit_idx, match_idx, free_idx, ins_idx;
  logic [NCNT-1:0]  inc;

  assign inv_line = inv_addr[IDX_W-1:0];
  assign inv_kind = overlap_kind(lvec[inv_line], inv_mask);
  assign ins      = inv_valid && (inv_kind != 2'd1);

  always_comb begin
    hit_any = 1'b0; match_any = 1'b0; free_any = 1'b0;
    hit_idx = '0;   match_idx = '0;   free_idx = '0;
    for (int i = MAP_DEPTH-1; i >= 0; i--) begin
      if (map_vld[i] && map_addr[i] == miss_addr) begin hit_any = 1'b1; hit_idx = PTR_W'(i); end
      if (map_vld[i] && map_addr[i] == inv_addr)  begin match_any = 1'b1; match_idx = PTR_W'(i); end
      if (!map_vld[i]) begin free_any = 1'b1; free_idx = PTR_W'(i); end
    end
  end

  assign ins_idx   = match_any ? match_idx : (free_any ? free_idx : rr);
  assign miss_kind = overlap_kind(map_vec[hit_idx], miss_mask);

  assign inc[0] = inv_valid && inv_kind == 2'd1;
  assign inc[1] = inv_valid && inv_kind == 2'd2;
  assign inc[2] = inv_valid && inv_kind == 2'd3;
  assign inc[3] = miss_valid && hit_any && miss_kind == 2'd1;
  assign inc[4] = miss_valid && hit_any && miss_kind == 2'd2;
  assign inc[5] = miss_valid && hit_any && miss_kind == 2'd3;

  assign stat_count = (stat_sel < 3'(NCNT)) ? cnt[stat_sel] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < LINES; l++) lvec[l] <= '0;
      for (int i = 0; i < MAP_DEPTH; i++) begin
        map_addr[i] <= '0;
        map_vec[i]  <= '0;
      end
      for (int k = 0; k < NCNT; k++) cnt[k] <= '0;
      map_vld        <= '0;
      rr             <= '0;
      inv_evt_valid  <= 1'b0;
      inv_evt_kind   <= 2'd0;
      miss_evt_valid <= 1'b0;
      miss_evt_kind  <= 2'd0;
    end else begin
      inv_evt_valid  <= inv_valid;
      inv_evt_kind   <= inv_valid ? inv_kind : 2'd0;
      miss_evt_valid <= miss_valid && hit_any;
      miss_evt_kind  <= (miss_valid && hit_any) ? miss_kind : 2'd0;

      if (fill_valid) lvec[fill_line] <= '0;
      if (acc_valid)
        lvec[acc_line] <= ((fill_valid && fill_line == acc_line) ? '0 : lvec[acc_line]) | acc_mask;
      if (inv_valid) lvec[inv_line] <= '0;

      if (miss_valid && hit_any) map_vld[hit_idx] <= 1'b0;
      if (ins) begin
        map_vld[ins_idx]  <= 1'b1;
        map_addr[ins_idx] <= inv_addr;
        map_vec[ins_idx]  <= inv_mask;
        if (!match_any && !free_any)
          rr <= (rr == PTR_W'(MAP_DEPTH-1)) ? '0 : rr + 1'b1;
      end

      for (int k = 0; k < NCNT; k++)
        if (inc[k] && cnt[k] != '1) cnt[k] <= cnt[k] + 1'b1;
    end
  end

  logic dup;
  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < MAP_DEPTH; i++)
      for (int j = i + 1; j < MAP_DEPTH; j++)
        if (map_vld[i] && map_vld[j] && map_addr[i] == map_addr[j]) dup = 1'b1;
  end

  // R8
  inv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_evt_valid |-> $past(inv_valid));

  // R2
  inv_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_evt_valid |-> inv_evt_kind != 2'd0);

  // R5
  miss_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt_valid |-> ($past(miss_valid) && $past(map_vld) != '0));

  // R6
  map_remove_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && hit_any && !ins) |=> ($countones(map_vld) + 1 == $past($countones(map_vld))));

  // R7
  map_unique_chk: assert property (@(posedge clk) disable iff (!rst_n) !dup);

  generate
    for (genvar g = 0; g < NCNT; g++) begin : g_cnt_chk
      // R9
      cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cnt[g] >= $past(cnt[g]));
    end
  endgenerate
endmodule

// File: tb/fs_probe_bench.sv
module fs_probe_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 16, LINES = 64, ADDR_W = 32, CNT_W = 3;
  localparam int IDX_W = $clog2(LINES);

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, fill_valid = 0, inv_valid = 0, miss_valid = 0;
  logic [IDX_W-1:0] acc_line = '0, fill_line = '0;
  logic [WORDS-1:0] acc_mask = '0, inv_mask = '0, miss_mask = '0;
  logic [ADDR_W-1:0] inv_addr = '0, miss_addr = '0;
  logic [2:0] stat_sel = '0;
  logic inv_evt_valid, miss_evt_valid;
  logic [1:0] inv_evt_kind, miss_evt_kind;
  logic [CNT_W-1:0] stat_count;

  int checks = 0, fails = 0;
  int exp_inv[$], exp_miss[$];
  string tag_inv[$], tag_miss[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fs_probe #(.WORDS(WORDS), .LINES(LINES), .ADDR_W(ADDR_W), .MAP_DEPTH(8), .CNT_W(CNT_W)) u_fs_probe (
    .clk, .rst_n, .acc_valid, .acc_line, .acc_mask, .fill_valid, .fill_line,
    .inv_valid, .inv_addr, .inv_mask, .miss_valid, .miss_addr, .miss_mask, .stat_sel,
    .inv_evt_valid, .inv_evt_kind, .miss_evt_valid, .miss_evt_kind, .stat_count);

  always @(negedge clk) if (rst_n) begin
    if (inv_evt_valid) begin
      checks++;
      if (exp_inv.size() == 0) begin
        fails++; $display("FAIL R8 unexpected invalidation event kind %0d, expected none", inv_evt_kind);
      end else begin
        int e; string t;
        e = exp_inv.pop_front(); t = tag_inv.pop_front();
        if (inv_evt_kind != e) begin
          fails++; $display("FAIL %s invalidation kind %0d, expected %0d", t, inv_evt_kind, e);
        end
      end
    end
    if (miss_evt_valid) begin
      checks++;
      if (exp_miss.size() == 0) begin
        fails++; $display("FAIL R6 unexpected miss event kind %0d, expected none", miss_evt_kind);
      end else begin
        int e; string t;
        e = exp_miss.pop_front(); t = tag_miss.pop_front();
        if (miss_evt_kind != e) begin
          fails++; $display("FAIL %s miss kind %0d, expected %0d", t, miss_evt_kind, e);
        end
      end
    end
  end

  task automatic do_acc(input int line, input logic [WORDS-1:0] m);
    @(negedge clk); acc_valid = 1; acc_line = IDX_W'(line); acc_mask = m;
    @(negedge clk); acc_valid = 0;
  endtask

  task automatic do_fill(input int line);
    @(negedge clk); fill_valid = 1; fill_line = IDX_W'(line);
    @(negedge clk); fill_valid = 0;
  endtask

  task automatic do_inv(input logic [ADDR_W-1:0] a, input logic [WORDS-1:0] m, input int e, input string t);
    exp_inv.push_back(e); tag_inv.push_back(t);
    @(negedge clk); inv_valid = 1; inv_addr = a; inv_mask = m;
    @(negedge clk); inv_valid = 0;
  endtask

  task automatic do_miss(input logic [ADDR_W-1:0] a, input logic [WORDS-1:0] m, input int e, input string t);
    if (e != 0) begin exp_miss.push_back(e); tag_miss.push_back(t); end
    @(negedge clk); miss_valid = 1; miss_addr = a; miss_mask = m;
    @(negedge clk); miss_valid = 0;
    @(negedge clk);
  endtask

  task automatic check_stat(input int sel, input int e, input string t);
    @(negedge clk); stat_sel = 3'(sel); #1;
    checks++;
    if (stat_count != CNT_W'(e)) begin
      fails++; $display("FAIL %s counter %0d = %0d, expected %0d", t, sel, stat_count, e);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    for (int s = 0; s < 6; s++) check_stat(s, 0, "R10");
    checks++;
    if (inv_evt_valid || miss_evt_valid) begin
      fails++; $display("FAIL R10 events %0b%0b, expected 00", inv_evt_valid, miss_evt_valid);
    end
    // R2 R3 false invalidation, R5 strict miss, R6 removal
    do_acc(1, 16'h000F);
    do_inv(32'd1, 16'h00F0, 3, "R2");
    do_miss(32'd1, 16'h0F00, 3, "R5");
    do_miss(32'd1, 16'h0F00, 0, "R6");
    // R1 true invalidation, R3 nothing stored
    do_acc(2, 16'h00F0); do_acc(2, 16'h000F);
    do_inv(32'd2, 16'h00FF, 1, "R1");
    do_miss(32'd2, 16'h00FF, 0, "R3");
    // R2 grey invalidation, R5 true miss
    do_acc(3, 16'h0003);
    do_inv(32'd3, 16'h0006, 2, "R2");
    do_miss(32'd3, 16'h0006, 1, "R5");
    // R1 fill clears, R5 grey miss
    do_acc(4, 16'h0001); do_fill(4);
    do_inv(32'd4, 16'h0001, 3, "R1");
    do_miss(32'd4, 16'h0003, 2, "R5");
    // R4 invalidation cleared line 1
    do_inv(32'd1, 16'h000F, 3, "R4");
    do_miss(32'd1, 16'h000F, 1, "R4");
    // R7 round-robin replacement of a full map
    for (int k = 0; k < 9; k++)
      do_inv(32'h1000 + (k << 6) + 10, 16'h1 << k, 3, "R7");
    do_miss(32'h1000 + 10, 16'h0001, 0, "R7");
    do_miss(32'h1000 + (1 << 6) + 10, 16'h8000, 3, "R7");
    do_miss(32'h1000 + (8 << 6) + 10, 16'h0100, 1, "R7");
    // R9 counters, false-invalidation counter saturated
    check_stat(0, 1, "R9"); check_stat(1, 1, "R9"); check_stat(2, 7, "R9");
    check_stat(3, 3, "R9"); check_stat(4, 1, "R9"); check_stat(5, 2, "R9");
    repeat (3) @(negedge clk);
    // R8 every expected pulse observed
    checks++;
    if (exp_inv.size() != 0 || exp_miss.size() != 0) begin
      fails++; $display("FAIL R8 pending events inv %0d miss %0d, expected 0 0", exp_inv.size(), exp_miss.size());
    end
    summary();
  end
endmodule